// File: doc/BRIEF.md
# Four-Channel Tamper Input Detector

This block watches four external tamper lines and turns a qualified tamper on any of them into a set of responses. Each line has its own active level, its own optional debounce and its own 2-bit response selector. One shared tick generator paces every debouncer. A global mode picks one of two qualification styles. The first is stability, where the level must be seen on two consecutive tick samples. The second is instant capture with a release hold-off. A further switch turns on two-of-three majority voting in the stability mode.

A qualified tamper latches a per-channel status bit. That bit stays set until it is cleared by writing 1 to its position. The status bits feed one combined interrupt. Each tamper also produces a one-cycle event pulse, and can wipe a small bank of general-purpose holding registers. A loop mode drives a slowly toggling shield signal off-chip. A channel set to that mode trips when its returning input no longer follows the shield.

Configuration arrives over a plain single-cycle register port. Apart from the enable bit, the configuration is frozen while the block is enabled. There is no streaming data path, so every pin is a plain control or status level with no valid/ready handshake and no back-pressure.

Top module: `tamper_detector`

## Requirements
- R1: Address 1 holds the channel configuration, with channel i in bits [4i+3:4i]: [1:0] is the response, [2] is the active level (1 means high is a tamper) and [3] enables debouncing. Address 0 holds the control word: [0] enable, [1] wipe-on-tamper, [2] instant-capture mode, [3] majority, [15:4] tick period. Writes to address 1, and to every control field except bit 0, take effect only while the enable bit is 0. Bit 0 is always writable, and every field reads back as stored.
- R2: Status sits at address 2, bits [3:0]. A bit is set by a tamper on its channel and holds until a write with a 1 in that position. A tamper in the same cycle as the clear wins.
- R3: With debouncing off, a level change on an input, applied before clock edge k, appears in status and on the event pin after edge k+3.
- R4: The active level bit of a channel selects whether high or low on its input counts as a tamper.
- R5: The tick fires once every period+1 cycles while enabled. In stability mode without majority, a channel qualifies after two consecutive tick samples show the tamper level and releases after two consecutive tick samples show the idle level.
- R6: In stability mode with majority on, the qualified level is the value held by at least two of the last three tick samples.
- R7: In instant-capture mode a debounced channel qualifies on the first cycle its level is active, even for a single-cycle pulse. It releases only when two consecutive tick samples are idle. The majority bit has no effect in this mode.
- R8: A channel trips once per rise of its qualified level. tamper_evt is high for exactly the cycle after each tripping cycle.
- R9: tamper_irq is high exactly while any status bit is set.
- R10: A channel whose response is 00 never sets status, events or wipes.
- R11: Addresses 4 and 5 are general-purpose registers that are writable at any time. A tamper clears both of them only when wipe-on-tamper is set, and the clear wins over a write in the same cycle.
- R12: While enabled, shield_out toggles on every tick. A channel with response 11 treats its input differing from shield_out (as it was two cycles earlier) as a tamper.
- R13: Clearing the enable bit resets the tick counter, the shield output and all qualifier state, but keeps status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr (combinational) |
| tamper_in | input | 4 | External tamper lines |
| shield_out | output | 1 | Toggling loop drive for response 11 |
| tamper_status | output | 4 | Sticky per-channel status |
| tamper_irq | output | 1 | Combined interrupt |
| tamper_evt | output | 1 | One-cycle event pulse per tamper |

## Verification
A qualifier stuck in a wrong state shows up on the ports in two ways. It either holds back or repeats the status bit and event pulse. When it repeats, a second event appears after the first without any new rise on the input. Errors in the tick counter or the shield phase show up as a shield_out toggle falling a cycle early or late. In loop mode that same error causes a false trip within two cycles of the misplaced toggle. A bad write-guard or clear path shows up at once on the next read of the affected address. A per-cycle reference compares status, interrupt, event and shield every cycle, so any of these faults is seen within one cycle of its first visible effect.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  typedef enum logic [1:0] {
    ACT_OFF   = 2'b00,
    ACT_EVENT = 2'b01,
    ACT_STAMP = 2'b10,
    ACT_LOOP  = 2'b11
  } act_e;

  localparam int CH_FIELD_W   = 4;
  localparam int CTRL_EN      = 0;
  localparam int CTRL_WIPE    = 1;
  localparam int CTRL_INSTANT = 2;
  localparam int CTRL_MAJ     = 3;
  localparam int CTRL_PER_LSB = 4;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_CHCFG  = 1;
  localparam int ADDR_STATUS = 2;
  localparam int ADDR_GP0    = 4;
endpackage

// File: rtl/tamper_tick.sv
module tamper_tick #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             tick,
  output logic             shield
);
  logic [PER_W-1:0] cnt_q;

  assign tick = en && (cnt_q == period);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q  <= '0;
      shield <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      shield <= ~shield;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tamper_chan.sv
module tamper_chan
  import tamper_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic raw_in,
  input  logic shield,
  input  logic pol,
  input  logic deb_en,
  input  logic instant,
  input  logic maj_en,
  input  act_e act,
  output logic trip
);
  logic       s1_q, s2_q, sh1_q, sh2_q;
  logic       qual_q, qual_d1_q;
  logic [2:0] hist_q, hist_nx;
  logic       lvl;

  // Two-stage synchronizers for the line and the matching shield delay
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      sh1_q <= 1'b0;
      sh2_q <= 1'b0;
    end else begin
      s1_q  <= raw_in;
      s2_q  <= s1_q;
      sh1_q <= shield;
      sh2_q <= sh1_q;
    end
  end

  always_comb begin
    lvl     = (act == ACT_LOOP) ? (s2_q ^ sh2_q) : (s2_q == pol);
    hist_nx = {hist_q[1:0], lvl};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      qual_q    <= 1'b0;
      qual_d1_q <= 1'b0;
      hist_q    <= '0;
    end else begin
      qual_d1_q <= qual_q;
      if (tick) hist_q <= hist_nx;
      if (!deb_en) begin
        qual_q <= lvl;
      end else if (instant) begin
        if (lvl) qual_q <= 1'b1;
        else if (tick && !hist_q[0]) qual_q <= 1'b0;
      end else if (tick) begin
        if (maj_en) qual_q <= ($countones(hist_nx) >= 2);
        else if (&hist_nx[1:0]) qual_q <= 1'b1;
        else if (~|hist_nx[1:0]) qual_q <= 1'b0;
      end
    end
  end

  assign trip = qual_q && !qual_d1_q && (act != ACT_OFF);
endmodule

// File: rtl/tamper_detector.sv
module tamper_detector
  import tamper_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DW     = 16,
  parameter int ADDR_W = 3,
  parameter int GP_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic [N_CH-1:0]   tamper_in,
  output logic              shield_out,
  output logic [N_CH-1:0]   tamper_status,
  output logic              tamper_irq,
  output logic              tamper_evt
);
  localparam int PER_W = DW - CTRL_PER_LSB;
  localparam int CFG_W = N_CH * CH_FIELD_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CHCFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);

  logic             en_q, wipe_q, instant_q, maj_q;
  logic [PER_W-1:0] per_q;
  logic [CFG_W-1:0] chcfg_q;
  logic [N_CH-1:0]  status_q, trips;
  logic             evt_q, tick;
  logic [DW-1:0]    gp_q [GP_N];

  logic wr_ctrl, wr_cfg, wr_stat, wipe_now;
  assign wr_ctrl  = cfg_we && (cfg_addr == A_CTRL);
  assign wr_cfg   = cfg_we && (cfg_addr == A_CFG);
  assign wr_stat  = cfg_we && (cfg_addr == A_STAT);
  assign wipe_now = (|trips) && wipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      wipe_q    <= 1'b0;
      instant_q <= 1'b0;
      maj_q     <= 1'b0;
      per_q     <= '0;
    end else if (wr_ctrl) begin
      en_q <= cfg_wdata[CTRL_EN];
      if (!en_q) begin
        wipe_q    <= cfg_wdata[CTRL_WIPE];
        instant_q <= cfg_wdata[CTRL_INSTANT];
        maj_q     <= cfg_wdata[CTRL_MAJ];
        per_q     <= cfg_wdata[DW-1:CTRL_PER_LSB];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chcfg_q <= '0;
    else if (wr_cfg && !en_q) chcfg_q <= cfg_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      evt_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~(wr_stat ? cfg_wdata[N_CH-1:0] : '0)) | trips;
      evt_q    <= |trips;
    end
  end

  tamper_tick #(.PER_W(PER_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_q),
    .period (per_q),
    .tick   (tick),
    .shield (shield_out)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tamper_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q),
      .tick    (tick),
      .raw_in  (tamper_in[i]),
      .shield  (shield_out),
      .pol     (chcfg_q[i*CH_FIELD_W+2]),
      .deb_en  (chcfg_q[i*CH_FIELD_W+3]),
      .instant (instant_q),
      .maj_en  (maj_q),
      .act     (act_e'(chcfg_q[i*CH_FIELD_W +: 2])),
      .trip    (trips[i])
    );
  end

  for (genvar g = 0; g < GP_N; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (!rst_n || wipe_now) gp_q[g] <= '0;
      else if (cfg_we && (cfg_addr == ADDR_W'(ADDR_GP0 + g))) gp_q[g] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_CTRL) begin
      cfg_rdata[CTRL_EN]                = en_q;
      cfg_rdata[CTRL_WIPE]              = wipe_q;
      cfg_rdata[CTRL_INSTANT]           = instant_q;
      cfg_rdata[CTRL_MAJ]               = maj_q;
      cfg_rdata[DW-1:CTRL_PER_LSB]      = per_q;
    end else if (cfg_addr == A_CFG) begin
      cfg_rdata[CFG_W-1:0] = chcfg_q;
    end else if (cfg_addr == A_STAT) begin
      cfg_rdata[N_CH-1:0] = status_q;
    end
    for (int g = 0; g < GP_N; g++)
      if (cfg_addr == ADDR_W'(ADDR_GP0 + g)) cfg_rdata = gp_q[g];
  end

  assign tamper_status = status_q;
  assign tamper_irq    = |status_q;
  assign tamper_evt    = evt_q;
endmodule

// File: rtl/tamper_checker.sv
module tamper_checker #(
  parameter int N_CH  = 4,
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [N_CH-1:0]  tamper_status,
  input logic             tamper_irq,
  input logic             tamper_evt,
  input logic             shield_out,
  input logic             en_q,
  input logic [CFG_W-1:0] chcfg_q
);
  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(chcfg_q));

  // R2
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ((tamper_status & $past(tamper_status)) == $past(tamper_status)));

  // R8
  evt_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_evt |-> (tamper_status != '0));

  // R9
  irq_rise_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tamper_irq) |-> tamper_evt);

  // R13
  shield_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !shield_out);
endmodule

bind tamper_detector tamper_checker #(.N_CH(N_CH), .CFG_W(CFG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .tamper_status (tamper_status),
  .tamper_irq    (tamper_irq),
  .tamper_evt    (tamper_evt),
  .shield_out    (shield_out),
  .en_q          (en_q),
  .chcfg_q       (chcfg_q)
);

// File: tb/tb_tamper_detector.sv
module tb_tamper_detector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [3:0]  drv = 4'b0010;
  logic [3:0]  loop_mask = 4'b0000;
  logic [3:0]  tamper_in;
  logic        shield_out, tamper_irq, tamper_evt;
  logic [3:0]  tamper_status;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tamper_in = drv ^ (loop_mask & {4{shield_out}});

  tamper_detector dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tamper_in(tamper_in),
    .shield_out(shield_out), .tamper_status(tamper_status),
    .tamper_irq(tamper_irq), .tamper_evt(tamper_evt)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference, updated on every rising edge
  logic [3:0]  m_s1, m_s2, m_q, m_qp, m_status;
  logic [2:0]  m_h [4];
  logic        m_sh1, m_sh2, m_shield, m_en, m_wipe, m_inst, m_maj, m_evt;
  logic [11:0] m_per, m_cnt;
  logic [15:0] m_cfg;

  always @(posedge clk) begin
    logic tk;
    logic [3:0] trip;
    logic [1:0] act;
    logic lvl, nq;
    logic [2:0] nh;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_q = 0; m_qp = 0; m_status = 0;
      m_sh1 = 0; m_sh2 = 0; m_shield = 0; m_en = 0; m_wipe = 0;
      m_inst = 0; m_maj = 0; m_evt = 0; m_per = 0; m_cnt = 0; m_cfg = 0;
      for (int c = 0; c < 4; c++) m_h[c] = 0;
    end else begin
      tk = m_en && (m_cnt == m_per);
      for (int c = 0; c < 4; c++) begin
        act = m_cfg[4*c +: 2];
        lvl = (act == 2'b11) ? (m_s2[c] ^ m_sh2) : (m_s2[c] == m_cfg[4*c+2]);
        trip[c] = m_q[c] && !m_qp[c] && (act != 2'b00);
        nq = m_q[c];
        nh = m_h[c];
        if (!m_en) begin
          nq = 0; nh = 0;
        end else begin
          if (tk) nh = {m_h[c][1:0], lvl};
          if (!m_cfg[4*c+3]) nq = lvl;
          else if (m_inst) begin
            if (lvl) nq = 1;
            else if (tk && !m_h[c][0]) nq = 0;
          end else if (tk) begin
            if (m_maj) nq = ((nh[0] + nh[1] + nh[2]) >= 2);
            else if (nh[1:0] == 2'b11) nq = 1;
            else if (nh[1:0] == 2'b00) nq = 0;
          end
        end
        m_qp[c] = m_en ? m_q[c] : 1'b0;
        m_q[c] = nq;
        m_h[c] = nh;
      end
      m_s2 = m_s1; m_s1 = tamper_in;
      m_sh2 = m_sh1; m_sh1 = m_shield;
      if (cfg_we && cfg_addr == 3'd2) m_status = m_status & ~cfg_wdata[3:0];
      m_status = m_status | trip;
      m_evt = |trip;
      if (!m_en) begin m_cnt = 0; m_shield = 0; end
      else if (tk) begin m_cnt = 0; m_shield = ~m_shield; end
      else m_cnt = m_cnt + 1;
      if (cfg_we && cfg_addr == 3'd1 && !m_en) m_cfg = cfg_wdata;
      if (cfg_we && cfg_addr == 3'd0) begin
        if (!m_en) begin
          m_wipe = cfg_wdata[1]; m_inst = cfg_wdata[2];
          m_maj = cfg_wdata[3]; m_per = cfg_wdata[15:4];
        end
        m_en = cfg_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R2 status vs model", 16'(tamper_status), 16'(m_status));
      check("R9 irq vs model", 16'(tamper_irq), 16'(|m_status));
      check("R8 evt vs model", 16'(tamper_evt), 16'(m_evt));
      check("R12 shield vs model", 16'(shield_out), 16'(m_shield));
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1 check(tag, cfg_rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  int evts;
  task automatic count_evt(input int n);
    evts = 0;
    repeat (n) begin
      @(negedge clk);
      if (tamper_evt) evts++;
    end
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, 16'h0000, "R1 reset ctrl");
    rd(3'd1, 16'h0000, "R1 reset chcfg");
    rd(3'd2, 16'h0000, "R2 reset status");
    check("R9 reset irq", 16'(tamper_irq), 16'h0);

    // ch0 evt hi-active, ch1 evt lo-active, ch2 stamp hi debounced, ch3 off
    wr(3'd1, 16'h4E15);
    wr(3'd0, 16'h0030);
    rd(3'd1, 16'h4E15, "R1 chcfg readback");
    rd(3'd0, 16'h0030, "R1 ctrl readback");
    wr(3'd0, 16'h0031);
    wr(3'd1, 16'hFFFF);
    rd(3'd1, 16'h4E15, "R1 chcfg write blocked");
    wr(3'd0, 16'hFFF3);
    rd(3'd0, 16'h0031, "R1 ctrl fields blocked");
    wait_n(4);

    // R3 latency, R8 single pulse
    @(negedge clk); drv[0] = 1'b1;
    wait_n(3);
    check("R3 status before latency", 16'(tamper_status), 16'h0);
    wait_n(1);
    check("R3 status after latency", 16'(tamper_status), 16'h1);
    check("R8 evt pulse", 16'(tamper_evt), 16'h1);
    count_evt(8);
    check("R8 no repeat evt", 16'(evts), 16'd0);
    drv[0] = 1'b0;
    wait_n(4);
    check("R2 sticky", 16'(tamper_status), 16'h1);
    check("R9 irq set", 16'(tamper_irq), 16'h1);
    wr(3'd2, 16'h0001);
    check("R2 cleared", 16'(tamper_status), 16'h0);
    check("R9 irq clear", 16'(tamper_irq), 16'h0);

    // R4 active-low channel
    drv[1] = 1'b0;
    wait_n(6);
    check("R4 low-active trip", 16'(tamper_status), 16'h2);
    drv[1] = 1'b1;
    wait_n(3);
    wr(3'd2, 16'h0002);

    // R10 response off
    drv[3] = 1'b1;
    count_evt(10);
    check("R10 off no evt", 16'(evts), 16'd0);
    check("R10 off no status", 16'(tamper_status), 16'h0);
    drv[3] = 1'b0;

    // R5 stability debounce on ch2
    drv[2] = 1'b1; wait_n(2); drv[2] = 1'b0;
    wait_n(12);
    check("R5 glitch rejected", 16'(tamper_status), 16'h0);
    drv[2] = 1'b1;
    wait_n(14);
    check("R5 steady accepted", 16'(tamper_status), 16'h4);
    drv[2] = 1'b0;
    wait_n(14);
    wr(3'd2, 16'h0004);

    // R6 majority: tick samples 1,0,1
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0038);
    wr(3'd0, 16'h0039);
    drv[2] = 1'b1; wait_n(4);
    drv[2] = 1'b0; wait_n(4);
    drv[2] = 1'b1; wait_n(4);
    drv[2] = 1'b0;
    wait_n(4);
    check("R6 majority accepted", 16'(tamper_status), 16'h4);
    wait_n(10);
    wr(3'd2, 16'h0004);

    // R7 instant capture, majority bit set but ignored
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h003C);
    wr(3'd0, 16'h003D);
    wait_n(3);
    drv[2] = 1'b1; @(negedge clk); drv[2] = 1'b0;
    count_evt(10);
    check("R7 one-cycle pulse caught", 16'(evts), 16'd1);
    check("R7 status", 16'(tamper_status), 16'h4);
    wait_n(20);
    wr(3'd2, 16'h0004);
    drv[2] = 1'b1; @(negedge clk); drv[2] = 1'b0;
    count_evt(10);
    check("R7 second pulse after release", 16'(evts), 16'd1);
    wr(3'd2, 16'h0004);

    // R11 wipe enabled
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0032);
    wr(3'd0, 16'h0033);
    wr(3'd4, 16'hA5A5);
    wr(3'd5, 16'h1234);
    rd(3'd4, 16'hA5A5, "R11 gp0 write");
    drv[0] = 1'b1; wait_n(6); drv[0] = 1'b0;
    rd(3'd4, 16'h0000, "R11 gp0 wiped");
    rd(3'd5, 16'h0000, "R11 gp1 wiped");
    wait_n(4);
    wr(3'd2, 16'h000F);
    // R11 wipe disabled
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0031);
    wr(3'd5, 16'h5A5A);
    drv[0] = 1'b1; wait_n(6); drv[0] = 1'b0;
    check("R11 trip seen", 16'(tamper_status), 16'h1);
    rd(3'd5, 16'h5A5A, "R11 gp kept without wipe");
    wait_n(4);
    wr(3'd2, 16'h000F);

    // R12 loop mode on ch3
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h3E15);
    loop_mask = 4'b1000;
    drv[3] = 1'b0;
    wr(3'd0, 16'h0031);
    evts = 0;
    for (int k = 0; k < 16; k++) begin
      logic prev;
      prev = shield_out;
      @(negedge clk);
      if (shield_out != prev) evts++;
    end
    check("R12 shield toggles per tick", 16'(evts), 16'd4);
    wait_n(10);
    check("R12 intact loop no trip", 16'(tamper_status), 16'h0);
    drv[3] = 1'b1;
    wait_n(6);
    check("R12 broken loop trips", 16'(tamper_status), 16'h8);

    // R13 disable keeps status, idles shield
    wr(3'd0, 16'h0000);
    wait_n(1);
    check("R13 shield idle", 16'(shield_out), 16'h0);
    rd(3'd2, 16'h0008, "R13 status kept");
    loop_mask = 4'b0000;
    wait_n(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule